// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Pins

This block is an eight-bit storage register with four operations picked by a two-bit mode input: keep the current value, move every bit one place up, move every bit one place down, or capture a full word at once. The word that is captured in parallel and the word that the register presents come through the same set of bidirectional pins. For synthesis those pins appear as a separate input vector, an output vector and one drive-enable signal, which the chip-level pad ring turns into true bidirectional pads.

Two serial inputs feed the bit that is vacated by each shift direction. Two serial outputs always show the lowest and the highest bit, whatever the state of the pin drivers, so several of these registers can be chained into a longer word. The drivers of the shared pins turn off when either of two active-low enables is deasserted, and they also turn off by themselves whenever the parallel-capture mode is selected, so that outside logic can place data on the pins without a fight. An active-low reset clears the register at once, without waiting for a clock.

The register is a plain control-and-data block with no flow control: each rising clock edge performs one operation, and the pins carry no valid/ready handshake.

Top module: `univ_shift_reg`

## Requirements
- R1: While `rst_n` is low the register holds all zeros (visible on `pin_out`, `ser_out_lo` and `ser_out_hi`) immediately, with no clock edge needed, and clock edges and `mode_sel` have no effect until `rst_n` returns high.
- R2: With `mode_sel` = 2'b00 a rising clock edge leaves all eight bits unchanged.
- R3: With `mode_sel` = 2'b01 a rising clock edge loads `ser_in_up` into bit 0 and the old bit i into bit i+1 for i from 0 to 6; old bit 7 is lost.
- R4: With `mode_sel` = 2'b10 a rising clock edge loads `ser_in_dn` into bit 7 and the old bit i+1 into bit i for i from 0 to 6; old bit 0 is lost.
- R5: With `mode_sel` = 2'b11 a rising clock edge loads bit n from `pin_in[n]` for every n.
- R6: `pin_out` always equals the current register contents, bit n on `pin_out[n]`.
- R7: `pin_oe` is low whenever `oe_a_n` or `oe_b_n` is high.
- R8: `pin_oe` is low whenever `mode_sel` = 2'b11, and it is high when both enables are low and `mode_sel` is not 2'b11.
- R9: `ser_out_lo` equals bit 0 and `ser_out_hi` equals bit 7 in every cycle, independent of `oe_a_n`, `oe_b_n` and `pin_oe`.
- R10: Hold, both shifts and parallel capture give the same results while `pin_oe` is low as while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations except reset act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_sel | input | 2 | Operation select: 00 keep, 01 move up, 10 move down, 11 parallel capture |
| ser_in_up | input | 1 | Serial bit entering bit 0 when moving up |
| ser_in_dn | input | 1 | Serial bit entering bit 7 when moving down |
| oe_a_n | input | 1 | Active-low pin drive enable, first |
| oe_b_n | input | 1 | Active-low pin drive enable, second |
| pin_in | input | 8 | Value seen on the shared pins |
| pin_out | output | 8 | Value to drive on the shared pins (register contents) |
| pin_oe | output | 1 | Drive enable for the shared pins |
| ser_out_lo | output | 1 | Bit 0, always driven |
| ser_out_hi | output | 1 | Bit 7, always driven |

## Verification
On every clock the embedded assertions check that each mode produces its one-edge result from the previous contents and serial inputs, that the drive enable is off in capture mode or when an enable is deasserted, and that the serial outputs track the end bits. The asynchronous nature of the clear, the fact that a clock edge during reset changes nothing, and the long chained sequences of moves and captures under both driver states are shown only by the bench scenarios, which compare every cycle against an independent model.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_KEEP    = 2'b00,
    OP_UP      = 2'b01,
    OP_DOWN    = 2'b10,
    OP_CAPTURE = 2'b11
  } shreg_op_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_up,
  input  logic             ser_dn,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  shreg_op_e op;
  assign op = shreg_op_e'(mode_sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_low
      assign from_below = ser_up;
    end else begin : g_low_n
      assign from_below = cur[i-1];
    end
    if (i == TOP) begin : g_high
      assign from_above = ser_dn;
    end else begin : g_high_n
      assign from_above = cur[i+1];
    end

    always_comb begin
      unique case (op)
        OP_KEEP:    nxt[i] = cur[i];
        OP_UP:      nxt[i] = from_below;
        OP_DOWN:    nxt[i] = from_above;
        OP_CAPTURE: nxt[i] = par_in[i];
        default:    nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/shreg_drive_ctl.sv
module shreg_drive_ctl
  import shreg_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output logic       drive_en
);
  logic capture_sel;
  logic enables_on;

  assign capture_sel = (shreg_op_e'(mode_sel) == OP_CAPTURE);
  assign enables_on  = ~(oe_a_n | oe_b_n);
  assign drive_en    = enables_on & ~capture_sel;

  always_comb begin
    // R8
    r8_capture_float_chk: assert (!(mode_sel == 2'b11 && drive_en));
    // R7
    r7_enable_gate_chk: assert (!((oe_a_n || oe_b_n) && drive_en));
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             ser_in_up,
  input  logic             ser_in_dn,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode_sel (mode_sel),
    .cur      (store_q),
    .par_in   (pin_in),
    .ser_up   (ser_in_up),
    .ser_dn   (ser_in_dn),
    .nxt      (store_d)
  );

  shreg_drive_ctl u_drive (
    .mode_sel (mode_sel),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .drive_en (pin_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  assign pin_out    = store_q;
  assign ser_out_lo = store_q[0];
  assign ser_out_hi = store_q[TOP];

  // R2
  r2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b00 |=> $stable(pin_out));
  // R3
  r3_move_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> (pin_out[0] == $past(ser_in_up)) &&
                          (pin_out[TOP:1] == $past(pin_out[TOP-1:0])));
  // R4
  r4_move_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b10 |=> (pin_out[TOP] == $past(ser_in_dn)) &&
                          (pin_out[TOP-1:0] == $past(pin_out[TOP:1])));
  // R5
  r5_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b11 |=> pin_out == $past(pin_in));
  // R9
  r9_serial_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_lo == pin_out[0]) && (ser_out_hi == pin_out[TOP]));
endmodule

// File: tb/univ_shift_reg_test.sv
module univ_shift_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       ser_in_up = 1'b0;
  logic       ser_in_dn = 1'b0;
  logic       oe_a_n = 1'b1;
  logic       oe_b_n = 1'b1;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out;
  logic       pin_oe;
  logic       ser_out_lo;
  logic       ser_out_hi;

  int total = 0;
  int bad = 0;
  bit model [8];

  always #10 clk = ~clk;

  univ_shift_reg uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ser_in_up(ser_in_up), .ser_in_dn(ser_in_dn),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe),
    .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
  );

  function automatic logic [7:0] model_word();
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = model[i];
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(string req);
    chk(req, pin_out, model_word());
    chk("R6", pin_out, model_word());
    chk("R9", {ser_out_hi, ser_out_lo}, {model[7], model[0]});
  endtask

  // one operation: inputs set after the falling edge, model updated at the
  // rising edge, outputs compared at the next falling edge
  task automatic step(logic [1:0] m, logic su, logic sd, logic [7:0] din,
                      logic ea, logic eb);
    bit nxt [8];
    string req;
    mode_sel = m; ser_in_up = su; ser_in_dn = sd; pin_in = din;
    oe_a_n = ea; oe_b_n = eb;
    #2;
    if (m == 2'b11)      chk("R8", pin_oe, 1'b0);
    else if (ea || eb)   chk("R7", pin_oe, 1'b0);
    else                 chk("R8", pin_oe, 1'b1);
    case (m)
      2'b00: begin req = "R2"; for (int i = 0; i < 8; i++) nxt[i] = model[i]; end
      2'b01: begin
        req = "R3";
        nxt[0] = su;
        for (int i = 1; i < 8; i++) nxt[i] = model[i-1];
      end
      2'b10: begin
        req = "R4";
        nxt[7] = sd;
        for (int i = 0; i < 7; i++) nxt[i] = model[i+1];
      end
      default: begin req = "R5"; for (int i = 0; i < 8; i++) nxt[i] = din[i]; end
    endcase
    if (ea || eb) req = {req, "/R10"};
    @(posedge clk);
    for (int i = 0; i < 8; i++) model[i] = nxt[i];
    @(negedge clk);
    check_outputs(req);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int lfsr;
    for (int i = 0; i < 8; i++) model[i] = 1'b0;
    #3;
    rst_n = 1'b0;
    #2;
    // R1 reset state before any clock edge
    check_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;

    step(2'b11, 0, 0, 8'hA5, 0, 0);   // R5 with enables on
    step(2'b00, 1, 1, 8'hFF, 0, 0);   // R2
    step(2'b01, 1, 0, 8'h00, 0, 0);   // R3
    step(2'b01, 0, 1, 8'h00, 0, 0);
    step(2'b10, 0, 1, 8'h00, 0, 0);   // R4
    step(2'b10, 1, 0, 8'h00, 0, 0);
    for (int k = 0; k < 9; k++) step(2'b01, 1, 0, 8'h00, 0, 0);   // fill with ones
    for (int k = 0; k < 9; k++) step(2'b10, 0, 0, 8'h00, 0, 0);   // drain to zero
    // R10 operations with drivers off
    step(2'b11, 0, 0, 8'h3C, 1, 0);
    step(2'b01, 1, 0, 8'h00, 0, 1);
    step(2'b10, 0, 1, 8'h00, 1, 1);
    step(2'b00, 0, 0, 8'h00, 1, 0);
    step(2'b11, 0, 0, 8'h81, 0, 1);

    lfsr = 32'h1ACE;
    for (int k = 0; k < 120; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[1:0], lfsr[2], lfsr[3], lfsr[11:4], lfsr[12], lfsr[13]);
    end

    // R1 asynchronous clear mid-cycle, then a clock edge while held
    step(2'b11, 0, 0, 8'hEE, 0, 0);
    #3;
    rst_n = 1'b0;
    #2;
    for (int i = 0; i < 8; i++) model[i] = 1'b0;
    check_outputs("R1");
    mode_sel = 2'b11; pin_in = 8'h77;
    @(posedge clk);
    @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    step(2'b01, 1, 0, 8'h00, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule